// File: doc/BRIEF.md
# Synchronous Burst Read Port with Suspend

This block is the device-side read front end of a burst-capable memory. A host selects the device with an active-low chip select and presents a start address together with an active-low address strobe. In synchronous mode the port counts device clock edges from that address latch. Once a programmable latency has elapsed it presents the first word. After that it streams consecutive words, one per clock. A ready indicator (WAIT) tells the host whether the data on the bus is valid yet. In asynchronous mode the device clock is ignored, and the addressed word appears a fixed number of system clocks after the latch.

The device clock is modelled as a clock-enable on the system clock: an edge with the enable low is a halted clock. The host can park a burst by stopping the clock and releasing output enable. It can do this while still in the initial latency or after words have started to flow. Reasserting output enable and restarting the clock continues the burst exactly where it stopped. The data pads and the WAIT pad are not driven as tri-state signals. They are given as values plus drive enables, which are high only while the device is both selected and output-enabled. The memory array is a computed word function: the word at address a is {a, ~a}.

A 16-bit read configuration register is loaded by an external command path through a plain write strobe. Bit 15 selects the mode (0 synchronous, 1 asynchronous). Bits 13:11 hold the latency code, and bit 10 sets the WAIT polarity. Bit 14 and bits 5:4 are reserved.

Top module: `burst_read_port`

## Requirements
- R1: After reset the configuration register reads 16'hBC00: asynchronous mode, latency code 7, WAIT polarity 1. The data output reads 0.
- R2: A register write stores every bit of the written value except bit 14 and bits 5:4, which always read 0. Writing 16'hFFFF reads back 16'hBFCF.
- R3: A write whose bits 13:11 hold 000 or 001 (reserved latency codes) keeps the previous latency field and updates all other bits.
- R4: In synchronous mode (bit 15 = 0), WAIT shows not-ready after an address latch. The data becomes word(start) and WAIT shows ready on exactly the Nth active clock edge after the latch, where N is the latency code value (2 to 7).
- R5: Every active clock edge after the first valid word advances the address by one, modulo 256, and presents word(a) = {a, ~a}. The address wraps from 8'hFF to 8'h00.
- R6: An edge with the clock enable low changes neither the burst address, nor the latency count, nor the data.
- R7: Edges while output enable is deasserted do not advance the burst. A suspend during the initial latency or after data has started resumes with the count and address it had when it stopped.
- R8: The data drive enable and the WAIT drive enable are high only while chip select and output enable are both asserted (both low).
- R9: With bit 10 = 1, WAIT high means not ready. With bit 10 = 0, WAIT low means not ready.
- R10: A latch (chip select low and address strobe low at a system clock edge) restarts the burst at the new address. It aborts any burst in progress, including a suspended one, regardless of the clock enable and output enable.
- R11: In asynchronous mode (bit 15 = 1), the clock enable is ignored. The data becomes word(latched address) on the third system clock after the latch, and WAIT is held at its ready level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Device clock enable; low models a halted clock |
| sel_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| adv_n | input | 1 | Address strobe, active low |
| addr_in | input | 8 | Start address |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 16 | Configuration write value |
| cfg_rdata | output | 16 | Configuration register contents |
| dq_out | output | 16 | Data pad value |
| dq_drv | output | 1 | Data pad drive enable |
| wait_out | output | 1 | WAIT pad value |
| wait_drv | output | 1 | WAIT pad drive enable |

## Verification
The hardest situation to reach is a suspend in the middle of the initial latency, followed by a restart that must land the first word on exactly the right edge. The stimulus first brings this about with a seven-clock latency. It gives three active edges, then releases output enable and keeps toggling the clock enable, so that those edges must be ignored. Output enable is then reasserted before the clock restarts. The same burst crosses the address wrap, is parked again after data, and is finally aborted by a latch while suspended.

// File: rtl/brp_pkg.sv
package brp_pkg;

    localparam int CFG_W     = 16;
    localparam int LAT_W     = 3;
    localparam int LAT_MIN   = 2;
    localparam logic [CFG_W-1:0] CFG_RST  = 16'hBC00;
    localparam logic [CFG_W-1:0] CFG_KEEP = 16'hBFCF;

    typedef struct packed {
        logic             async_mode;
        logic             rsv_hi;
        logic [LAT_W-1:0] lat_code;
        logic             wait_pol;
        logic             hold_ext;
        logic             wait_early;
        logic             seq_order;
        logic             edge_sel;
        logic [1:0]       rsv_lo;
        logic             wrap_on;
        logic [2:0]       blen;
    } rcfg_t;

    function automatic logic lat_code_ok(input logic [LAT_W-1:0] code);
        return code >= LAT_W'(LAT_MIN);
    endfunction

endpackage

// File: rtl/brp_cfg_reg.sv
module brp_cfg_reg
    import brp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [CFG_W-1:0] wdata,
    output rcfg_t            cfg
);
    rcfg_t nxt;

    always_comb begin
        nxt = rcfg_t'(wdata & CFG_KEEP);
        if (!lat_code_ok(nxt.lat_code))
            nxt.lat_code = cfg.lat_code;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cfg <= rcfg_t'(CFG_RST);
        else if (wr)
            cfg <= nxt;
    end
endmodule

// File: rtl/brp_seq.sv
module brp_seq
    import brp_pkg::*;
#(
    parameter int AW        = 8,
    parameter int DW        = 2 * AW,
    parameter int ASYNC_DLY = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             latch,
    input  logic             step,
    input  logic             async_mode,
    input  logic [LAT_W-1:0] lat_code,
    input  logic [AW-1:0]    addr_in,
    output logic [DW-1:0]    data_q,
    output logic             valid_q
);
    localparam int CW = $clog2(ASYNC_DLY + 8);

    logic [AW-1:0] addr_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_nx;
    logic [CW-1:0] target;

    function automatic logic [DW-1:0] word_of(input logic [AW-1:0] a);
        return DW'({a, ~a});
    endfunction

    assign cnt_nx = cnt_q + 1'b1;
    assign target = async_mode ? CW'(ASYNC_DLY) : CW'(lat_code);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            cnt_q   <= '0;
            valid_q <= 1'b0;
            data_q  <= '0;
        end else if (latch) begin
            addr_q  <= addr_in;
            cnt_q   <= '0;
            valid_q <= 1'b0;
        end else if (async_mode || step) begin
            if (!valid_q) begin
                cnt_q <= cnt_nx;
                if (cnt_nx == target) begin
                    valid_q <= 1'b1;
                    data_q  <= word_of(addr_q);
                end
            end else if (!async_mode) begin
                addr_q <= addr_q + 1'b1;
                data_q <= word_of(addr_q + 1'b1);
            end
        end
    end
endmodule

// File: rtl/brp_pad_ctl.sv
module brp_pad_ctl (
    input  logic sel_n,
    input  logic oe_n,
    input  logic async_mode,
    input  logic wait_pol,
    input  logic valid,
    output logic dq_drv,
    output logic wait_drv,
    output logic wait_out
);
    logic gate_on;
    logic ready;

    assign gate_on  = !sel_n && !oe_n;
    assign dq_drv   = gate_on;
    assign wait_drv = gate_on;
    assign ready    = async_mode || valid;
    assign wait_out = ready ? !wait_pol : wait_pol;
endmodule

// File: rtl/burst_read_port.sv
module burst_read_port
    import brp_pkg::*;
#(
    parameter  int AW        = 8,
    parameter  int ASYNC_DLY = 3,
    localparam int DW        = 2 * AW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clk_en,
    input  logic             sel_n,
    input  logic             oe_n,
    input  logic             adv_n,
    input  logic [AW-1:0]    addr_in,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    output logic [DW-1:0]    dq_out,
    output logic             dq_drv,
    output logic             wait_out,
    output logic             wait_drv
);
    rcfg_t cfg;
    logic  latch;
    logic  step;
    logic  valid;

    assign latch     = !sel_n && !adv_n;
    assign step      = clk_en && !sel_n && !oe_n;
    assign cfg_rdata = CFG_W'(cfg);

    brp_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr    (cfg_wr),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    brp_seq #(.AW(AW), .DW(DW), .ASYNC_DLY(ASYNC_DLY)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .latch      (latch),
        .step       (step),
        .async_mode (cfg.async_mode),
        .lat_code   (cfg.lat_code),
        .addr_in    (addr_in),
        .data_q     (dq_out),
        .valid_q    (valid)
    );

    brp_pad_ctl u_pad (
        .sel_n      (sel_n),
        .oe_n       (oe_n),
        .async_mode (cfg.async_mode),
        .wait_pol   (cfg.wait_pol),
        .valid      (valid),
        .dq_drv     (dq_drv),
        .wait_drv   (wait_drv),
        .wait_out   (wait_out)
    );
endmodule

// File: rtl/brp_chk.sv
module brp_chk #(
    parameter int AW = 8,
    parameter int DW = 2 * AW
) (
    input logic          clk,
    input logic          rst,
    input logic          clk_en,
    input logic          sel_n,
    input logic          oe_n,
    input logic          adv_n,
    input logic          cfg_wr,
    input logic [15:0]   cfg_rdata,
    input logic [DW-1:0] dq_out,
    input logic          wait_out
);
    logic sync_quiet;
    assign sync_quiet = !cfg_rdata[15] && !cfg_wr;

    // R6
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sync_quiet && !clk_en && (sel_n || adv_n)) |=> $stable(dq_out));

    // R7
    suspend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sync_quiet && oe_n && (sel_n || adv_n)) |=> $stable(dq_out));

    // R10
    relatch_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (sync_quiet && !sel_n && !adv_n) |=> (wait_out == cfg_rdata[10]));

    // R5
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (sync_quiet && (wait_out != cfg_rdata[10]) && clk_en && !sel_n && !oe_n && adv_n)
        |=> (dq_out[DW-1 -: AW] == AW'($past(dq_out[DW-1 -: AW]) + 1'b1)));

    // R11
    async_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata[15] && !cfg_wr) |=> (wait_out == !cfg_rdata[10]));
endmodule

bind burst_read_port brp_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .clk_en    (clk_en),
    .sel_n     (sel_n),
    .oe_n      (oe_n),
    .adv_n     (adv_n),
    .cfg_wr    (cfg_wr),
    .cfg_rdata (cfg_rdata),
    .dq_out    (dq_out),
    .wait_out  (wait_out)
);

// File: tb/sim_burst_read_port.sv
`timescale 1ns/1ps
module sim_burst_read_port;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clk_en = 1'b0, sel_n = 1'b1, oe_n = 1'b1, adv_n = 1'b1;
    logic [7:0]  addr_in = '0;
    logic        cfg_wr = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata, dq_out;
    logic        dq_drv, wait_out, wait_drv;

    int    n_run = 0, n_fail = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    burst_read_port u0 (
        .clk(clk), .rst(rst), .clk_en(clk_en), .sel_n(sel_n), .oe_n(oe_n),
        .adv_n(adv_n), .addr_in(addr_in), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .dq_out(dq_out), .dq_drv(dq_drv),
        .wait_out(wait_out), .wait_drv(wait_drv)
    );

    // behavioural reference state
    int m_addr, m_cnt, m_cfg, m_data;
    bit m_valid;

    function automatic int word(input int a);
        return ((a & 255) << 8) | (~a & 255);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_addr = 0; m_cnt = 0; m_valid = 0; m_data = 0; m_cfg = 'hBC00;
        end else begin
            bit async_m;
            int lat, nc;
            async_m = m_cfg[15];
            lat = (m_cfg >> 11) & 7;
            if (!sel_n && !adv_n) begin
                m_addr = addr_in; m_cnt = 0; m_valid = 0;
            end else if (async_m) begin
                if (!m_valid) begin
                    m_cnt++;
                    if (m_cnt == 3) begin m_valid = 1; m_data = word(m_addr); end
                end
            end else if (clk_en && !sel_n && !oe_n) begin
                if (!m_valid) begin
                    m_cnt++;
                    if (m_cnt == lat) begin m_valid = 1; m_data = word(m_addr); end
                end else begin
                    m_addr = (m_addr + 1) & 255;
                    m_data = word(m_addr);
                end
            end
            if (cfg_wr) begin
                nc = cfg_wdata & 'hBFCF;
                if (((cfg_wdata >> 11) & 7) < 2) nc = (nc & ~'h3800) | (m_cfg & 'h3800);
                m_cfg = nc;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            bit pol, exp_wait, exp_drv;
            pol = m_cfg[10];
            exp_wait = (m_cfg[15] || m_valid) ? !pol : pol;
            exp_drv = !sel_n && !oe_n;
            chk(dq_out == 16'(m_data), cur_req, dq_out, m_data);
            chk(wait_out == exp_wait, cur_req, wait_out, exp_wait);
            chk(dq_drv == exp_drv && wait_drv == exp_drv, "R8", {dq_drv, wait_drv}, {exp_drv, exp_drv});
            chk(cfg_rdata == 16'(m_cfg), "R2", cfg_rdata, m_cfg);
        end
    end

    task automatic cyc(input bit s, input bit o, input bit a, input bit c, input logic [7:0] ad);
        sel_n = s; oe_n = o; adv_n = a; clk_en = c; addr_in = ad;
        @(posedge clk); #1;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 1, 1, 8'h00);
    endtask

    task automatic wr(input logic [15:0] d);
        cfg_wr = 1'b1; cfg_wdata = d;
        cyc(1, 1, 1, 0, 8'h00);
        cfg_wr = 1'b0;
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 20000, 0);
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset state
        chk(cfg_rdata == 16'hBC00, "R1", cfg_rdata, 16'hBC00);
        chk(dq_out == 16'h0000, "R1", dq_out, 0);
        chk(dq_drv == 1'b0, "R8", dq_drv, 0);

        // R2 reserved bits read zero
        cur_req = "R2";
        wr(16'hFFFF);
        chk(cfg_rdata == 16'hBFCF, "R2", cfg_rdata, 16'hBFCF);
        wr(16'h2400);
        chk(cfg_rdata == 16'h2400, "R2", cfg_rdata, 16'h2400);
        // R3 reserved latency code 001 keeps field
        cur_req = "R3";
        wr(16'h0C00);
        chk(cfg_rdata == 16'h2400, "R3", cfg_rdata, 16'h2400);

        // R4 latency 4 from latch
        cur_req = "R4";
        cyc(0, 0, 0, 1, 8'h10);
        run(3);
        chk(wait_out == 1'b1, "R4", wait_out, 1);
        run(1);
        chk(wait_out == 1'b0, "R4", wait_out, 0);
        chk(dq_out == 16'(word(8'h10)), "R4", dq_out, word(8'h10));

        // R5 sequential words
        cur_req = "R5";
        run(3);
        chk(dq_out == 16'(word(8'h13)), "R5", dq_out, word(8'h13));

        // R6 halted clock
        cur_req = "R6";
        for (int i = 0; i < 3; i++) cyc(0, 0, 1, 0, 8'h00);
        chk(dq_out == 16'(word(8'h13)), "R6", dq_out, word(8'h13));
        for (int i = 0; i < 4; i++) cyc(0, 0, 1, i % 2 == 0, 8'h00);
        chk(dq_out == 16'(word(8'h15)), "R6", dq_out, word(8'h15));

        // R7 suspend during latency, latency 7
        cur_req = "R7";
        wr(16'h3C00);
        cyc(0, 0, 0, 1, 8'hFC);
        run(3);
        for (int i = 0; i < 2; i++) cyc(0, 1, 1, 0, 8'h00);
        for (int i = 0; i < 3; i++) cyc(0, 1, 1, 1, 8'h00);
        chk(dq_drv == 1'b0 && wait_drv == 1'b0, "R8", {dq_drv, wait_drv}, 0);
        chk(wait_out == 1'b1, "R7", wait_out, 1);
        cyc(0, 0, 1, 0, 8'h00);
        chk(wait_drv == 1'b1, "R8", wait_drv, 1);
        run(3);
        chk(wait_out == 1'b1, "R7", wait_out, 1);
        run(1);
        chk(dq_out == 16'(word(8'hFC)), "R7", dq_out, word(8'hFC));
        run(4);
        chk(dq_out == 16'(word(8'h00)), "R5", dq_out, word(8'h00));
        // R7 suspend after data
        for (int i = 0; i < 4; i++) cyc(0, 1, 1, 1, 8'h00);
        chk(dq_out == 16'(word(8'h00)), "R7", dq_out, word(8'h00));
        run(2);
        chk(dq_out == 16'(word(8'h02)), "R7", dq_out, word(8'h02));

        // R10 latch while suspended aborts
        cur_req = "R10";
        cyc(0, 1, 1, 0, 8'h00);
        cyc(0, 1, 0, 0, 8'h40);
        chk(wait_out == 1'b1, "R10", wait_out, 1);
        run(7);
        chk(dq_out == 16'(word(8'h40)), "R10", dq_out, word(8'h40));

        // R9 polarity 0
        cur_req = "R9";
        wr(16'h3800);
        cyc(0, 0, 0, 1, 8'h80);
        chk(wait_out == 1'b0, "R9", wait_out, 0);
        run(7);
        chk(wait_out == 1'b1, "R9", wait_out, 1);
        chk(dq_out == 16'(word(8'h80)), "R9", dq_out, word(8'h80));

        // R8 selected but deselected chip
        cur_req = "R8";
        cyc(1, 0, 1, 1, 8'h00);
        chk(dq_drv == 1'b0 && wait_drv == 1'b0, "R8", {dq_drv, wait_drv}, 0);

        // R11 asynchronous mode, clock enable held low
        cur_req = "R11";
        wr(16'h9400);
        cyc(0, 0, 0, 0, 8'h33);
        cyc(0, 0, 1, 0, 8'h00);
        cyc(0, 0, 1, 0, 8'h00);
        chk(wait_out == 1'b0, "R11", wait_out, 0);
        chk(dq_out == 16'(word(8'h80)), "R11", dq_out, word(8'h80));
        cyc(0, 0, 1, 0, 8'h00);
        chk(dq_out == 16'(word(8'h33)), "R11", dq_out, word(8'h33));

        // R3 code 000 keeps latency 010
        cur_req = "R3";
        wr(16'h0400);
        chk(cfg_rdata == 16'h1400, "R3", cfg_rdata, 16'h1400);

        repeat (2) @(posedge clk);
        summary();
    end
endmodule